// File: doc/BRIEF.md
# Reorder Buffer with Operand Bypass

This block is a circular in-order retirement queue for an out-of-order execution core. At issue, an instruction claims the entry at the tail. The entry records the destination register, the instruction address and whether the instruction is a store. The entry index goes back to the issuer as the result tag. Execution units finish in any order and write a result value and an exception flag into the entry named by the tag. The oldest entry retires once it is complete. A retiring register-writing entry drives the register-file write port. A retiring store drives a one-cycle release pulse that allows the real memory write. Every retirement presents the instruction address of the entry.

When the oldest entry completes with an exception, the block freezes. It accepts no new entries and retires nothing, and it holds the faulting instruction address on an exception port until a flush empties the queue. A lookup port serves operand bypass. Given a source register, it searches all occupied non-store entries and selects the youngest one that targets that register. It returns that entry's value if the result is ready, or the entry's tag as a wait token if it is not. When no entry matches, the lookup returns the register-file read data that the user supplies.

Top module: `reorder_buf`

## Requirements
- R1: After a synchronous reset the queue is empty. `alloc_ready` is 1, `alloc_tag` is 0, `rf_we`, `mem_release` and `exc_valid` are 0, and a lookup returns `rf_rdata` with `lk_ready` = 1.
- R2: An allocation takes place on a clock edge where `alloc_req` and `alloc_ready` are both 1. It claims tag `alloc_tag`, and the next tag is (tag + 1) mod 8. `alloc_ready` is 0 while 8 entries are occupied or while frozen, and a request made then has no effect.
- R3: A write-back to an occupied tag marks that entry complete and stores its value and exception flag. A write-back to an unoccupied tag changes nothing.
- R4: Retirement is strictly in allocation order. In any cycle where the oldest entry is complete, has no exception, is not a store and the block is not frozen, `rf_we` = 1 with that entry's destination on `rf_waddr` and its value on `rf_wdata`. The entry leaves the queue at that clock edge. Younger completed entries wait.
- R5: A store entry that retires under the same conditions gives `mem_release` = 1 and `rf_we` = 0 for that cycle.
- R6: During every retirement (`rf_we` or `mem_release` high), `retire_pc` equals the address recorded for that entry at allocation.
- R7: One edge after the oldest entry is found complete with an exception, `exc_valid` = 1 and `exc_pc` holds that entry's address. Until a flush arrives, `alloc_ready`, `rf_we` and `mem_release` stay 0 and `exc_pc` does not change.
- R8: On the edge after `flush` = 1, all entries are empty, `exc_valid` = 0, `alloc_tag` = 0 and `alloc_ready` = 1.
- R9: For a lookup of register r, the block selects the youngest occupied non-store entry whose destination is r. If that entry is complete, `lk_ready` = 1, `lk_pending` = 0 and `lk_value` is its value.
- R10: If the selected entry is not yet complete, `lk_pending` = 1, `lk_ready` = 0 and `lk_tag` is that entry's index.
- R11: When no occupied non-store entry targets r, `lk_ready` = 1, `lk_pending` = 0 and `lk_value` = `rf_rdata`.
- R12: An allocation and a retirement on the same edge leave the occupancy unchanged. The next free tag still advances by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all entries and leave the frozen state |
| alloc_req | input | 1 | Request a new entry |
| alloc_dst | input | 5 | Destination register of the new instruction |
| alloc_pc | input | 32 | Instruction address of the new instruction |
| alloc_store | input | 1 | New instruction is a store |
| alloc_ready | output | 1 | An entry can be claimed this cycle |
| alloc_tag | output | 3 | Tag the next allocation receives |
| wb_en | input | 1 | Result write-back strobe |
| wb_tag | input | 3 | Entry written back |
| wb_value | input | 32 | Result value |
| wb_exc | input | 1 | Result raised an exception |
| rf_we | output | 1 | Register-file write enable (retirement) |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |
| mem_release | output | 1 | Retiring store may write memory |
| retire_pc | output | 32 | Address of the retiring instruction |
| exc_valid | output | 1 | Frozen on a faulting instruction |
| exc_pc | output | 32 | Address of the faulting instruction |
| lk_reg | input | 5 | Source register looked up |
| rf_rdata | input | 32 | Register-file value for `lk_reg` |
| lk_ready | output | 1 | `lk_value` is usable |
| lk_pending | output | 1 | Operand still in flight |
| lk_tag | output | 3 | Tag to wait on when pending |
| lk_value | output | 32 | Operand value |

## Verification
Allocation at the tail and retirement at the head often fall on the same edge. A write-back can also land in the same cycle that a lookup selects its target. The stimulus keeps allocation requests frequent and issues write-backs to random incomplete entries, so a nearly full queue often claims and frees an entry at the same time. A behavioural queue model predicts the tag sequence and the occupancy on every clock. The lookup is judged against the state before the edge, so a write-back in the same cycle must not be visible yet.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int ROB_DEPTH  = 8;
  localparam int ROB_REG_W  = 5;
  localparam int ROB_DATA_W = 32;
  localparam int ROB_PC_W   = 32;

  typedef enum logic [1:0] {
    BYP_FILE  = 2'd0,
    BYP_READY = 2'd1,
    BYP_WAIT  = 2'd2
  } byp_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             full
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire)  tail <= (tail == LAST) ? '0 : tail + 1'b1;
      if (retire_fire) head <= (head == LAST) ? '0 : head + 1'b1;
      case ({alloc_fire, retire_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full = (count == CNT_W'(DEPTH));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  a_r2_full_holds_tail: assert property (@(posedge clk) disable iff (rst)
    (full && !flush) |=> (tail == $past(tail)));

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && head == tail));
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        alloc_fire,
  input  logic [IDX_W-1:0]            alloc_idx,
  input  logic [REG_W-1:0]            alloc_dst,
  input  logic [PC_W-1:0]             alloc_pc,
  input  logic                        alloc_store,
  input  logic                        wb_en,
  input  logic [IDX_W-1:0]            wb_tag,
  input  logic [DATA_W-1:0]           wb_value,
  input  logic                        wb_exc,
  input  logic                        retire_fire,
  input  logic [IDX_W-1:0]            head_idx,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [DEPTH-1:0]            valid,
  output logic [DEPTH-1:0]            done,
  output logic [DEPTH-1:0]            fault,
  output logic [DEPTH-1:0]            is_store,
  output logic [DEPTH-1:0][REG_W-1:0] dst_vec,
  output logic [DATA_W-1:0]           head_value,
  output logic [PC_W-1:0]             head_pc,
  output logic [DATA_W-1:0]           rd_value
);
  logic [DATA_W-1:0] value_mem [DEPTH];
  logic [PC_W-1:0]   pc_mem    [DEPTH];

  logic wb_hit;
  assign wb_hit = wb_en && valid[wb_tag];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic take, land, leave;
    assign take  = alloc_fire && (alloc_idx == IDX_W'(i));
    assign land  = wb_hit && (wb_tag == IDX_W'(i));
    assign leave = retire_fire && (head_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst || flush)  valid[i] <= 1'b0;
      else if (take)     valid[i] <= 1'b1;
      else if (leave)    valid[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        done[i]  <= 1'b0;
        fault[i] <= 1'b0;
      end else if (take) begin
        done[i]  <= 1'b0;
        fault[i] <= 1'b0;
      end else if (land) begin
        done[i]  <= 1'b1;
        fault[i] <= wb_exc;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        dst_vec[i]  <= '0;
        is_store[i] <= 1'b0;
      end else if (take) begin
        dst_vec[i]  <= alloc_dst;
        is_store[i] <= alloc_store;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wb_hit)     value_mem[wb_tag] <= wb_value;
    if (alloc_fire) pc_mem[alloc_idx] <= alloc_pc;
  end

  assign head_value = value_mem[head_idx];
  assign head_pc    = pc_mem[head_idx];
  assign rd_value   = value_mem[rd_idx];

  a_r3_wb_marks_done: assert property (@(posedge clk) disable iff (rst)
    (wb_hit && !(alloc_fire && alloc_idx == wb_tag)) |=> done[$past(wb_tag)]);

  a_r2_alloc_free_slot: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |-> !valid[alloc_idx]);
endmodule

// File: rtl/rob_bypass.sv
module rob_bypass #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int REG_W = 5
) (
  input  logic [IDX_W-1:0]            head,
  input  logic [DEPTH-1:0]            valid,
  input  logic [DEPTH-1:0]            is_store,
  input  logic [DEPTH-1:0][REG_W-1:0] dst_vec,
  input  logic [REG_W-1:0]            lk_reg,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  localparam int PW = IDX_W + 1;

  logic [DEPTH-1:0] match;
  assign match = valid & ~is_store & eq_vec(dst_vec, lk_reg);

  function automatic logic [DEPTH-1:0] eq_vec(
    input logic [DEPTH-1:0][REG_W-1:0] d, input logic [REG_W-1:0] r);
    for (int i = 0; i < DEPTH; i++) eq_vec[i] = (d[i] == r);
  endfunction

  // Walk from oldest to youngest; the last match seen is the youngest.
  always_comb begin
    logic [PW-1:0] j;
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      j = {1'b0, head} + PW'(k);
      if (j >= PW'(DEPTH)) j = j - PW'(DEPTH);
      if (match[j[IDX_W-1:0]]) begin
        hit     = 1'b1;
        hit_idx = j[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf #(
  parameter int DEPTH  = rob_pkg::ROB_DEPTH,
  parameter int REG_W  = rob_pkg::ROB_REG_W,
  parameter int DATA_W = rob_pkg::ROB_DATA_W,
  parameter int PC_W   = rob_pkg::ROB_PC_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc_req,
  input  logic [REG_W-1:0]  alloc_dst,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic              alloc_store,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_exc,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_release,
  output logic [PC_W-1:0]   retire_pc,
  output logic              exc_valid,
  output logic [PC_W-1:0]   exc_pc,
  input  logic [REG_W-1:0]  lk_reg,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              lk_ready,
  output logic              lk_pending,
  output logic [IDX_W-1:0]  lk_tag,
  output logic [DATA_W-1:0] lk_value
);
  import rob_pkg::*;

  logic [IDX_W-1:0]            head, tail;
  logic                        full, frozen;
  logic                        alloc_fire, retire_fire, fault_seen;
  logic [DEPTH-1:0]            valid, done, fault, is_store;
  logic [DEPTH-1:0][REG_W-1:0] dst_vec;
  logic [DATA_W-1:0]           head_value, rd_value;
  logic [PC_W-1:0]             head_pc;
  logic                        hit;
  logic [IDX_W-1:0]            hit_idx;
  byp_kind_e                   kind;

  assign alloc_ready = !full && !frozen;
  assign alloc_fire  = alloc_req && alloc_ready;
  assign alloc_tag   = tail;

  assign retire_fire = valid[head] && done[head] && !fault[head] && !frozen;
  assign fault_seen  = valid[head] && done[head] &&  fault[head] && !frozen;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_fire(alloc_fire), .retire_fire(retire_fire),
    .head(head), .tail(tail), .full(full)
  );

  rob_entries #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_entries (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_fire(alloc_fire), .alloc_idx(tail), .alloc_dst(alloc_dst),
    .alloc_pc(alloc_pc), .alloc_store(alloc_store),
    .wb_en(wb_en), .wb_tag(wb_tag), .wb_value(wb_value), .wb_exc(wb_exc),
    .retire_fire(retire_fire), .head_idx(head), .rd_idx(hit_idx),
    .valid(valid), .done(done), .fault(fault), .is_store(is_store),
    .dst_vec(dst_vec), .head_value(head_value), .head_pc(head_pc),
    .rd_value(rd_value)
  );

  rob_bypass #(.DEPTH(DEPTH), .REG_W(REG_W)) u_bypass (
    .head(head), .valid(valid), .is_store(is_store), .dst_vec(dst_vec),
    .lk_reg(lk_reg), .hit(hit), .hit_idx(hit_idx)
  );

  // Freeze on a faulting oldest entry; only a flush releases it.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      frozen <= 1'b0;
    end else if (fault_seen) begin
      frozen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             exc_pc <= '0;
    else if (fault_seen) exc_pc <= head_pc;
  end

  assign exc_valid   = frozen;
  assign rf_we       = retire_fire && !is_store[head];
  assign mem_release = retire_fire &&  is_store[head];
  assign rf_waddr    = dst_vec[head];
  assign rf_wdata    = head_value;
  assign retire_pc   = head_pc;

  always_comb begin
    if (!hit)             kind = BYP_FILE;
    else if (done[hit_idx]) kind = BYP_READY;
    else                  kind = BYP_WAIT;
  end

  assign lk_ready   = (kind != BYP_WAIT);
  assign lk_pending = (kind == BYP_WAIT);
  assign lk_tag     = hit_idx;
  assign lk_value   = (kind == BYP_FILE) ? rf_rdata : rd_value;

  a_r7_freeze_holds_head: assert property (@(posedge clk) disable iff (rst)
    (frozen && !flush) |=> (head == $past(head)));

  a_r7_exc_pc_stable: assert property (@(posedge clk) disable iff (rst)
    (frozen && !flush) |=> $stable(exc_pc));

  a_r10_one_lookup_kind: assert property (@(posedge clk) disable iff (rst)
    lk_ready != lk_pending);

  a_r5_store_no_rf_write: assert property (@(posedge clk) disable iff (rst)
    !(rf_we && mem_release));
endmodule

// File: tb/reorder_buf_bench.sv
module reorder_buf_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst, flush, alloc_req, alloc_store, wb_en, wb_exc;
  logic [4:0]  alloc_dst, lk_reg;
  logic [31:0] alloc_pc, wb_value, rf_rdata;
  logic [2:0]  wb_tag;
  logic        alloc_ready, rf_we, mem_release, exc_valid, lk_ready, lk_pending;
  logic [2:0]  alloc_tag, lk_tag;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata, retire_pc, exc_pc, lk_value;

  always #10 clk = ~clk;

  reorder_buf u_reorder_buf (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_req(alloc_req), .alloc_dst(alloc_dst), .alloc_pc(alloc_pc),
    .alloc_store(alloc_store), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .wb_en(wb_en), .wb_tag(wb_tag), .wb_value(wb_value), .wb_exc(wb_exc),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_release(mem_release), .retire_pc(retire_pc),
    .exc_valid(exc_valid), .exc_pc(exc_pc),
    .lk_reg(lk_reg), .rf_rdata(rf_rdata), .lk_ready(lk_ready),
    .lk_pending(lk_pending), .lk_tag(lk_tag), .lk_value(lk_value)
  );

  typedef struct {
    int          tag;
    logic [4:0]  dst;
    logic [31:0] pc;
    bit          st;
    bit          dn;
    bit          ex;
    logic [31:0] val;
  } ent_t;

  ent_t        q[$];
  int          tail_m;
  bit          frz_m;
  logic [31:0] xpc_m;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit head_fire();
    return q.size() > 0 && q[0].dn && !q[0].ex && !frz_m;
  endfunction

  function automatic bit head_fault();
    return q.size() > 0 && q[0].dn && q[0].ex && !frz_m;
  endfunction

  task automatic compare_outputs(input bit prev_flush, input bit prev_both);
    bit          exp_rdy, fire;
    int          m;
    exp_rdy = (q.size() < DEPTH) && !frz_m;
    fire    = head_fire();
    chk(alloc_ready == exp_rdy, "R2 alloc_ready", 32'(alloc_ready), 32'(exp_rdy));
    if (exp_rdy) chk(alloc_tag == 3'(tail_m), "R2 alloc_tag", 32'(alloc_tag), 32'(tail_m));
    if (prev_flush) chk(alloc_tag == 3'd0 && !exc_valid && alloc_ready, "R8 flushed",
                        {alloc_ready, exc_valid, 27'd0, alloc_tag}, 32'h8000_0000);
    if (prev_both) chk(alloc_ready == exp_rdy, "R12 occupancy", 32'(alloc_ready), 32'(exp_rdy));
    chk(rf_we == (fire && !q[0].st), "R4 rf_we", 32'(rf_we), 32'(fire && !q[0].st));
    chk(mem_release == (fire && q[0].st), "R5 mem_release", 32'(mem_release),
        32'(fire && q[0].st));
    if (fire && !q[0].st) begin
      chk(rf_waddr == q[0].dst, "R4 rf_waddr", 32'(rf_waddr), 32'(q[0].dst));
      chk(rf_wdata == q[0].val, "R4 rf_wdata", rf_wdata, q[0].val);
    end
    if (fire) chk(retire_pc == q[0].pc, "R6 retire_pc", retire_pc, q[0].pc);
    chk(exc_valid == frz_m, "R7 exc_valid", 32'(exc_valid), 32'(frz_m));
    if (frz_m) chk(exc_pc == xpc_m, "R7 exc_pc", exc_pc, xpc_m);
    m = -1;
    for (int k = 0; k < q.size(); k++)
      if (!q[k].st && q[k].dst == lk_reg) m = k;
    if (m < 0) begin
      chk(lk_ready && !lk_pending, "R11 no match ready", {lk_ready, lk_pending}, 32'd2);
      chk(lk_value == rf_rdata, "R11 file value", lk_value, rf_rdata);
    end else if (q[m].dn) begin
      chk(lk_ready && !lk_pending, "R9 youngest ready", {lk_ready, lk_pending}, 32'd2);
      chk(lk_value == q[m].val, "R9 R3 bypass value", lk_value, q[m].val);
    end else begin
      chk(!lk_ready && lk_pending, "R10 pending flag", {lk_ready, lk_pending}, 32'd1);
      chk(lk_tag == 3'(q[m].tag), "R10 wait tag", 32'(lk_tag), 32'(q[m].tag));
    end
  endtask

  task automatic update_model(input bit do_alloc);
    bit fire, flt;
    fire = head_fire();
    flt  = head_fault();
    if (flush) begin
      q.delete();
      tail_m = 0;
      frz_m  = 0;
    end else begin
      if (wb_en)
        for (int k = 0; k < q.size(); k++)
          if (q[k].tag == int'(wb_tag)) begin
            q[k].dn  = 1;
            q[k].ex  = wb_exc;
            q[k].val = wb_value;
          end
      if (fire) void'(q.pop_front());
      else if (flt) begin
        frz_m = 1;
        xpc_m = q[0].pc;
      end
      if (do_alloc) begin
        ent_t e;
        e.tag = tail_m; e.dst = alloc_dst; e.pc = alloc_pc; e.st = alloc_store;
        e.dn = 0; e.ex = 0; e.val = '0;
        q.push_back(e);
        tail_m = (tail_m + 1) % DEPTH;
      end
    end
  endtask

  initial begin
    int frz_cycles;
    bit prev_flush, prev_both, do_alloc;
    rst = 1; flush = 0; alloc_req = 0; alloc_store = 0; wb_en = 0; wb_exc = 0;
    alloc_dst = 0; lk_reg = 0; alloc_pc = 0; wb_value = 0; rf_rdata = 32'h5555_aaaa;
    wb_tag = 0;
    tail_m = 0; frz_m = 0; xpc_m = 0; frz_cycles = 0;
    prev_flush = 0; prev_both = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1;
    // R1: empty after reset
    chk(alloc_ready && alloc_tag == 0 && !rf_we && !mem_release && !exc_valid,
        "R1 reset state", {alloc_ready, rf_we, mem_release, exc_valid, 25'd0, alloc_tag},
        32'h8000_0000);
    chk(lk_ready && lk_value == rf_rdata, "R1 reset lookup", lk_value, rf_rdata);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      flush       = frz_m && (frz_cycles >= 3) || (!frz_m && ($urandom % 300 == 0));
      alloc_req   = (cyc < 20) ? 1'b1 : ($urandom % 4 != 0);
      alloc_dst   = 5'($urandom % 4);
      alloc_pc    = 32'h0000_1000 + 32'(cyc) * 4;
      alloc_store = ($urandom % 5 == 0);
      lk_reg      = 5'($urandom % 6);
      rf_rdata    = $urandom;
      wb_en = 0; wb_exc = 0; wb_tag = 0; wb_value = $urandom;
      if (cyc >= 20) begin
        int pend[$];
        for (int k = 0; k < q.size(); k++) if (!q[k].dn) pend.push_back(q[k].tag);
        if (pend.size() > 0 && $urandom % 3 != 0) begin
          wb_en  = 1;
          wb_tag = 3'(pend[$urandom % pend.size()]);
          wb_exc = ($urandom % 24 == 0);
        end else if ($urandom % 6 == 0 && q.size() < DEPTH) begin
          // write-back to an unoccupied tag: must be ignored (R3)
          wb_en  = 1;
          wb_tag = 3'((tail_m + DEPTH - 1 - 0) % DEPTH);
          for (int k = 0; k < q.size(); k++) if (q[k].tag == int'(wb_tag)) wb_en = 0;
          wb_exc = 1;
        end
      end
      #1;
      compare_outputs(prev_flush, prev_both);
      do_alloc   = alloc_req && (q.size() < DEPTH) && !frz_m && !flush;
      prev_both  = do_alloc && head_fire();
      prev_flush = flush;
      @(posedge clk);
      update_model(do_alloc);
      frz_cycles = frz_m ? frz_cycles + 1 : 0;
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule